// File: doc/BRIEF.md
# Frame Timing, Vertical-Blank Status and NMI Generator

This block is the timekeeper of a video picture generator. Every clock is one dot. It walks a beam position across 341 dots per scanline and 262 scanlines per frame, keeps a frame-parity bit, and holds the three status flags that a host processor polls: vertical blank, sprite-zero hit and sprite overflow. The sprite pipeline only sends one-cycle set pulses for its two flags. This block decides when each flag is set, cleared or suppressed.

The host reads status through a read strobe. While the strobe is high, the read data is already valid on the output. At the end of that cycle the read clears the vertical-blank flag and pulses a clear for the shared two-write address toggle, which sits in a neighbouring block. The interrupt line to the host is high exactly while vertical blank is set and the control register's interrupt-enable bit is set.

When rendering is on, odd frames drop the last dot of the final scanline. This keeps the frame cadence of the display.

Top module: `vblank_status_unit`

## Requirements
- R1: After synchronous reset the dot counter, scanline counter, frame parity, interrupt line and all three flags are 0. The dot counter counts 0 to 340 and the scanline counter counts 0 to 261.
- R2: Vertical blank reads as clear while the position is scanline 241, dot 0 or dot 1. It is set on the clock edge that ends scanline 241 dot 1, so it is visible from dot 2.
- R3: The clock edge that ends dot 1 of scanline 261 clears all three flags. If a set pulse for sprite-zero hit or overflow arrives in that same cycle, the clear wins.
- R4: Status read data is bit 7 vertical blank, bit 6 sprite-zero hit, bit 5 overflow, and bits 4:0 the open-bus latch input. It is combinational and always driven. For example, vertical blank set with the latch at 0x1B gives 0x9B.
- R5: A cycle with the read strobe high clears vertical blank at its end and raises the toggle-clear output during that cycle.
- R6: A read on scanline 241 dot 1 returns vertical blank clear and stops the flag being set in that frame. A read on dot 0 returns clear but does not stop the set.
- R7: The interrupt line equals vertical blank AND interrupt enable, with no delay. Raising the enable while vertical blank is set raises the line in the same cycle.
- R8: A sprite-zero-hit or overflow set pulse sets its flag from the next cycle. The flag stays set until the scanline 261 clear, and status reads leave it untouched.
- R9: If the frame parity is odd and either rendering-enable input is high during scanline 261 dot 339, the next position is scanline 0 dot 0, so the frame lasts 341x262-1 dots. In every other case the frame lasts 341x262 dots.
- R10: The frame-parity output toggles exactly when the position wraps from scanline 261 to scanline 0 dot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| show_bg | input | 1 | Background rendering enable |
| show_spr | input | 1 | Sprite rendering enable |
| nmi_enable | input | 1 | Control-register interrupt enable (bit 7) |
| status_rd | input | 1 | Status read strobe, one cycle per read |
| hit_set | input | 1 | Sprite-zero-hit set pulse |
| ovf_set | input | 1 | Sprite-overflow set pulse |
| open_bus_lo | input | 5 | Open-bus latch bits shown in read data 4:0 |
| dot | output | DOT_W | Current dot within the scanline |
| line | output | LINE_W | Current scanline |
| odd_frame | output | 1 | Frame parity, 1 on odd frames |
| status_data | output | 8 | Status read data |
| toggle_clr | output | 1 | Clear pulse for the shared write toggle |
| nmi | output | 1 | Interrupt request to the host |

## Verification
The bench goes after the three dots around the vertical-blank set edge. A design that sets the flag one dot early shows it set on dot 1. A design that ignores the race lets a dot-1 read be followed by a set flag. A design that treats the dot-0 read as a race loses vertical blank for the whole frame. It also measures whole frame lengths for both parities with rendering on and off. An off-by-one skip point, or a skip that ignores parity or the enables, changes a length by one dot. Set pulses land in the same cycle as the pre-render clear, and reads are scattered through the frame. A design that lets a set beat the clear, or that lets reads clear the sprite flags, shows stale bits 6:5.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    localparam int LATCH_W = 5;

    typedef struct packed {
        logic vblank;
        logic spr0_hit;
        logic overflow;
    } vbs_flags_t;

    // Status byte: flags on top, open-bus latch underneath.
    function automatic logic [7:0] pack_status(input vbs_flags_t f,
                                               input logic [LATCH_W-1:0] latch);
        return {f, latch};
    endfunction

    // One-dot update of the flag triple.
    function automatic vbs_flags_t step_flags(input vbs_flags_t cur,
                                              input logic pre_clear,
                                              input logic vbl_edge,
                                              input logic rd,
                                              input logic hit_in,
                                              input logic ovf_in);
        vbs_flags_t nxt;
        nxt = cur;
        if (pre_clear) begin
            nxt = '0;
        end else begin
            if (vbl_edge && !rd)
                nxt.vblank = 1'b1;
            else if (rd)
                nxt.vblank = 1'b0;
            nxt.spr0_hit = cur.spr0_hit | hit_in;
            nxt.overflow = cur.overflow | ovf_in;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/vbs_beam_counter.sv
module vbs_beam_counter #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int DOT_W           = $clog2(DOTS_PER_LINE),
    parameter int LINE_W          = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              render_on,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output logic              odd_frame
);

    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [DOT_W-1:0]  DOT_SKIP  = DOT_W'(DOTS_PER_LINE - 2);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);

    logic on_last_line;
    logic short_line;
    logic end_of_line;

    assign on_last_line = (line == LINE_LAST);
    assign short_line   = on_last_line && odd_frame && render_on;
    assign end_of_line  = (dot == DOT_LAST) || (short_line && dot == DOT_SKIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            dot       <= '0;
            line      <= '0;
            odd_frame <= 1'b0;
        end else if (end_of_line) begin
            dot <= '0;
            if (on_last_line) begin
                line      <= '0;
                odd_frame <= ~odd_frame;
            end else begin
                line <= line + 1'b1;
            end
        end else begin
            dot <= dot + 1'b1;
        end
    end

    assert_pos_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (dot <= DOT_LAST) && (line <= LINE_LAST));

    assert_parity_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (line == LINE_LAST && dot == DOT_LAST)
        |=> (line == '0 && dot == '0 && odd_frame != $past(odd_frame)));

    assert_odd_skip_R9: assert property (@(posedge clk) disable iff (rst)
        (line == LINE_LAST && dot == DOT_SKIP && odd_frame && render_on)
        |=> (line == '0 && dot == '0));

    assert_no_skip_R9: assert property (@(posedge clk) disable iff (rst)
        (line == LINE_LAST && dot == DOT_SKIP && !(odd_frame && render_on))
        |=> (dot == DOT_LAST && $stable(odd_frame)));

endmodule

// File: rtl/vbs_flag_regs.sv
module vbs_flag_regs
    import vbs_pkg::*;
#(
    parameter int LINES_PER_FRAME = 262,
    parameter int VBLANK_LINE     = 241,
    parameter int DOT_W           = 9,
    parameter int LINE_W          = $clog2(LINES_PER_FRAME)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DOT_W-1:0]   dot,
    input  logic [LINE_W-1:0]  line,
    input  logic               status_rd,
    input  logic               hit_set,
    input  logic               ovf_set,
    input  logic [LATCH_W-1:0] open_bus_lo,
    output vbs_flags_t         flags,
    output logic [7:0]         status_data
);

    localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES_PER_FRAME - 1);
    localparam logic [LINE_W-1:0] VBL_LINE = LINE_W'(VBLANK_LINE);
    localparam logic [DOT_W-1:0]  EDGE_DOT = DOT_W'(1);

    logic vbl_edge;
    logic pre_clear;

    assign vbl_edge  = (line == VBL_LINE) && (dot == EDGE_DOT);
    assign pre_clear = (line == PRE_LINE) && (dot == EDGE_DOT);

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= step_flags(flags, pre_clear, vbl_edge, status_rd, hit_set, ovf_set);
    end

    assign status_data = pack_status(flags, open_bus_lo);

    assert_vbl_set_R2: assert property (@(posedge clk) disable iff (rst)
        (vbl_edge && !status_rd) |=> flags.vblank);

    assert_vbl_early_R2: assert property (@(posedge clk) disable iff (rst)
        (line == VBL_LINE && dot <= EDGE_DOT) |-> !status_data[7]);

    assert_pre_clear_R3: assert property (@(posedge clk) disable iff (rst)
        pre_clear |=> (status_data[7:5] == 3'b000));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> !flags.vblank);

    assert_race_R6: assert property (@(posedge clk) disable iff (rst)
        (vbl_edge && status_rd) |=> !status_data[7]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flags.spr0_hit && !pre_clear) |=> flags.spr0_hit);

    assert_hit_set_R8: assert property (@(posedge clk) disable iff (rst)
        (hit_set && !pre_clear) |=> status_data[6]);

endmodule

// File: rtl/vblank_status_unit.sv
module vblank_status_unit
    import vbs_pkg::*;
#(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBLANK_LINE     = 241,
    parameter int DOT_W           = $clog2(DOTS_PER_LINE),
    parameter int LINE_W          = $clog2(LINES_PER_FRAME)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               show_bg,
    input  logic               show_spr,
    input  logic               nmi_enable,
    input  logic               status_rd,
    input  logic               hit_set,
    input  logic               ovf_set,
    input  logic [LATCH_W-1:0] open_bus_lo,
    output logic [DOT_W-1:0]   dot,
    output logic [LINE_W-1:0]  line,
    output logic               odd_frame,
    output logic [7:0]         status_data,
    output logic               toggle_clr,
    output logic               nmi
);

    localparam logic [LINE_W-1:0] VBL_LINE = LINE_W'(VBLANK_LINE);

    vbs_flags_t flags;
    logic       render_on;

    assign render_on = show_bg | show_spr;

    vbs_beam_counter #(
        .DOTS_PER_LINE  (DOTS_PER_LINE),
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .DOT_W          (DOT_W),
        .LINE_W         (LINE_W)
    ) i_beam (
        .clk      (clk),
        .rst      (rst),
        .render_on(render_on),
        .dot      (dot),
        .line     (line),
        .odd_frame(odd_frame)
    );

    vbs_flag_regs #(
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .VBLANK_LINE    (VBLANK_LINE),
        .DOT_W          (DOT_W),
        .LINE_W         (LINE_W)
    ) i_flags (
        .clk        (clk),
        .rst        (rst),
        .dot        (dot),
        .line       (line),
        .status_rd  (status_rd),
        .hit_set    (hit_set),
        .ovf_set    (ovf_set),
        .open_bus_lo(open_bus_lo),
        .flags      (flags),
        .status_data(status_data)
    );

    // Level output: follows the flag and the enable with no register.
    assign nmi        = flags.vblank & nmi_enable;
    assign toggle_clr = status_rd;

    assert_nmi_window_R7: assert property (@(posedge clk) disable iff (rst)
        nmi |-> (line >= VBL_LINE));

    assert_nmi_rise_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(nmi_enable) && status_data[7]) |-> nmi);

    assert_nmi_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !nmi_enable |-> !nmi);

endmodule

// File: tb/test_vblank_status_unit.sv
`timescale 1ns/1ps
module test_vblank_status_unit;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // main instance signals
    logic       rst = 1'b1;
    logic       bg = 1'b0, spr = 1'b0, en = 1'b0, rd = 1'b0, hs = 1'b0, os = 1'b0;
    logic [4:0] ob = '0;
    logic [8:0] dot, line;
    logic       odd, tog, nmi;
    logic [7:0] sdata;

    // reduced-frame instance signals (8 lines, vblank on line 5)
    logic       s_rst = 1'b1;
    logic       s_render = 1'b0, s_rd = 1'b0;
    logic [4:0] s_ob = '0;
    logic [8:0] s_dot;
    logic [2:0] s_line;
    logic       s_odd, s_tog, s_nmi;
    logic [7:0] s_data;

    vblank_status_unit i_vblank_status_unit (
        .clk(clk), .rst(rst), .show_bg(bg), .show_spr(spr), .nmi_enable(en),
        .status_rd(rd), .hit_set(hs), .ovf_set(os), .open_bus_lo(ob),
        .dot(dot), .line(line), .odd_frame(odd), .status_data(sdata),
        .toggle_clr(tog), .nmi(nmi)
    );

    vblank_status_unit #(.LINES_PER_FRAME(8), .VBLANK_LINE(5)) i_vblank_status_unit_small (
        .clk(clk), .rst(s_rst), .show_bg(s_render), .show_spr(1'b0), .nmi_enable(1'b1),
        .status_rd(s_rd), .hit_set(1'b0), .ovf_set(1'b0), .open_bus_lo(s_ob),
        .dot(s_dot), .line(s_line), .odd_frame(s_odd), .status_data(s_data),
        .toggle_clr(s_tog), .nmi(s_nmi)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (line %0d dot %0d)",
                     tag, act, exp, line, dot);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // bench model of the main instance
    int m_dot, m_line;
    bit m_odd, m_v, m_h, m_o;

    function automatic bit model_short(input bit render);
        return (m_line == 261) && (m_dot == 339) && m_odd && render;
    endfunction

    task automatic model_advance();
        bit pre, vedge;
        pre   = (m_line == 261) && (m_dot == 1);
        vedge = (m_line == 241) && (m_dot == 1);
        if (pre) begin
            m_v = 0; m_h = 0; m_o = 0;
        end else begin
            if (vedge && !rd) m_v = 1;
            else if (rd)      m_v = 0;
            m_h = m_h | hs;
            m_o = m_o | os;
        end
        if (m_dot == 340 || model_short(bg | spr)) begin
            m_dot = 0;
            if (m_line == 261) begin
                m_line = 0;
                m_odd  = ~m_odd;
            end else begin
                m_line = m_line + 1;
            end
        end else begin
            m_dot = m_dot + 1;
        end
    endtask

    task automatic small_frame(input bit render, input int rdot, input bit exp_set,
                               input int exp_len, input bit exp_odd);
        int len;
        len = 0;
        check("R10 small parity at frame start", s_odd, exp_odd);
        do begin
            s_render = render;
            s_rd = (s_line == 3'd5 && s_dot == 9'(rdot));
            s_ob = 5'h1B;
            #1;
            if (s_line == 3'd5 && s_dot == 9'(rdot))
                check("R6 read before set edge returns clear", s_data[7], 0);
            if (s_line == 3'd5 && s_dot == 9'd2) begin
                check("R6 vblank after race window", s_data[7], exp_set);
                if (exp_set)
                    check("R4 status byte with latch 0x1B", s_data, 8'h9B);
            end
            step();
            s_rd = 1'b0;
            len++;
        end while (!(s_line == 3'd0 && s_dot == 9'd0));
        check("R9 frame length", len, exp_len);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;

        // R1: reset state
        check("R1 reset dot", dot, 0);
        check("R1 reset line", line, 0);
        check("R1 reset parity", odd, 0);
        check("R1 reset nmi", nmi, 0);
        check("R1 reset flags", sdata[7:5], 0);
        m_dot = 0; m_line = 0; m_odd = 0; m_v = 0; m_h = 0; m_o = 0;

        for (int c = 0; c < 89342 + 60; c++) begin
            rd = ($urandom % 97) == 0;
            hs = (($urandom % 400) == 0) && (m_line < 240);
            os = (($urandom % 400) == 0) && (m_line < 240);
            ob = 5'($urandom);
            bg = 1'($urandom);
            spr = 1'($urandom);
            if (($urandom % 50) == 0) en = ~en;
            if (m_line == 100 && m_dot == 0) hs = 1'b1;
            if (m_line == 100 && m_dot == 5) os = 1'b1;
            if (m_line == 241 && m_dot <= 4)  begin en = 1'b0; rd = (m_dot == 0); end
            if (m_line == 241 && m_dot >= 5 && m_dot <= 30) begin en = 1'b1; rd = 1'b0; end
            if (m_line == 241 && m_dot == 31) rd = 1'b1;
            if (m_line == 261 && m_dot == 1) begin hs = 1'b1; os = 1'b1; end
            #1;
            check("R1 dot counter", dot, m_dot);
            check("R1 line counter", line, m_line);
            check("R10 frame parity", odd, m_odd);
            check("R2 vblank bit", sdata[7], m_v);
            check("R8 sprite flags", sdata[6:5], {m_h, m_o});
            check("R4 latch bits", sdata[4:0], ob);
            check("R7 nmi level", nmi, m_v & en);
            check("R5 toggle clear", tog, rd);
            if (m_line == 241 && m_dot == 0) check("R2 clear on dot 0", sdata[7], 0);
            if (m_line == 241 && m_dot == 2) check("R2 R6 set after dot-0 read", sdata[7], 1);
            if (m_line == 241 && m_dot == 4) check("R7 no nmi while disabled", nmi, 0);
            if (m_line == 241 && m_dot == 5) check("R7 nmi on enable", nmi, 1);
            if (m_line == 241 && m_dot == 32) check("R5 read cleared vblank", sdata[7], 0);
            if (m_line == 261 && m_dot == 0) check("R8 flags still set", sdata[6:5], 2'b11);
            if (m_line == 261 && m_dot == 2) check("R3 pre-render clear wins", sdata[7:5], 0);
            model_advance();
            step();
        end
        rd = 1'b0; hs = 1'b0; os = 1'b0;

        // reduced-frame instance: skip and race corners
        s_rst = 1'b0;
        small_frame(1'b1, 1, 1'b0, 8 * 341, 1'b0);
        small_frame(1'b1, 0, 1'b1, 8 * 341 - 1, 1'b1);
        small_frame(1'b1, 0, 1'b1, 8 * 341, 1'b0);
        small_frame(1'b0, 0, 1'b1, 8 * 341, 1'b1);
        check("R10 parity after four frames", s_odd, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule